// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A memory-mapped timer with several independent channels behind a simple single-cycle read/write register port. Each channel holds a 56-bit down counter that advances on ticks from its own power-of-two prescaler. A channel runs either periodically, reloading its interval every time it expires, or once, stopping at zero. Each expiry raises a per-channel status bit. The status bits are gathered into one shared register and cleared by writing one. A single interrupt line combines the pending channels that are enabled.

Software starts a channel by writing an interval and then setting the enable and reload bits together. It reads the live count back as a low word and then a high word. The high word is captured when the low word is read, so the two reads belong to the same instant. A channel loaded with all ones in periodic mode runs free, and the bitwise complement of its count rises steadily, which makes it usable as a time base.

Top module: `dcount_timer`

## Requirements
- R1: After reset every register reads 0 (interrupt enables, status, and each channel's control, interval and count) and `irq_o` is low.
- R2: Channel n occupies the byte offsets 0x10+0x20*n (control), +0x14 (interval low 32 bits), +0x18 (interval high, 24 bits, upper bits read 0), +0x1C (count low) and +0x20 (count high). The control word holds run enable in bit 0, reload request in bit 1, the prescaler select in bits 6:4 and the one-shot flag in bit 7. All other bits read 0.
- R3: Reload bit 1 stays set until the channel's next prescaler tick. On that tick the counter takes the interval value and bit 1 then reads 0. No expiry happens on a reload tick.
- R4: On every other tick the counter decreases by one. A tick that finds the count at 1 or 0 is an expiry, so a channel started with interval I expires I ticks after its load tick.
- R5: In periodic mode (bit 7 clear) an expiry loads the interval again on the same tick and counting continues, raising status on every expiry.
- R6: In one-shot mode (bit 7 set) an expiry leaves the count at 0 and clears bit 0, so no later expiry occurs.
- R7: Prescaler select k gives one tick every 2^k clocks while enabled. The prescaler restarts from zero while the channel is disabled, so the first tick comes 2^k clocks after the enabling write takes effect.
- R8: Status bit n at offset 0x04 is set on channel n's expiry. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as the clear wins.
- R9: `irq_o` is high exactly when some status bit n is set while bit n of the enable register at offset 0x00 is set.
- R10: Clearing bit 0 stops the counter from the clock after that write. The count then stays unchanged, which is well inside the two-clock stop bound.
- R11: Reading count low returns bits 31:0 of the live count and captures bits 55:32 in the same cycle. Reading count high returns that captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr, valid in the same cycle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A write takes effect at the clock edge that ends its access cycle. With prescaler select 0, the load happens one edge later, and every following edge moves the count by one. Status therefore becomes visible I+1 edges after the starting write, and `irq_o` follows status with no added register. The bench counts each access as exactly one cycle and derives every expected value from that count. It samples read data and the interrupt at mid-cycle, the only point in the cycle where the value shows the state after the previous edge. The prescaled case shifts the load to 2^k edges after enabling, and it is checked one cycle on each side of that edge.

// File: rtl/dcount_pkg.sv
package dcount_pkg;

   // shared register window layout (byte offsets)
   localparam int unsigned IEN_OFS    = 'h00;
   localparam int unsigned IST_OFS    = 'h04;
   localparam int unsigned CH_BASE    = 'h10;
   localparam int unsigned CH_STRIDE  = 'h20;
   localparam int unsigned CTL_REL    = 'h00;
   localparam int unsigned IVL_LO_REL = 'h04;
   localparam int unsigned IVL_HI_REL = 'h08;
   localparam int unsigned CNT_LO_REL = 'h0C;
   localparam int unsigned CNT_HI_REL = 'h10;

   localparam int unsigned PSEL_W = 3;

   // decoded control word of one channel
   typedef struct packed {
      logic              one_shot;
      logic [PSEL_W-1:0] psel;
      logic              rld;
      logic              en;
   } ctl_t;

endpackage

// File: rtl/dcount_prescale.sv
module dcount_prescale #(
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned DIV_W = (1 << SEL_W) - 1;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("dcount_prescale: SEL_W must be 1..4");
   end

   logic [DIV_W-1:0] acc_q;
   logic [DIV_W-1:0] lim;

   always_comb begin
      lim  = ~({DIV_W{1'b1}} << sel);
      tick = run && (acc_q == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc_q <= '0;
      else if (!run)       acc_q <= '0;
      else if (tick)       acc_q <= '0;
      else                 acc_q <= acc_q + 1'b1;
   end
endmodule

// File: rtl/dcount_channel.sv
module dcount_channel
   import dcount_pkg::*;
#(
   parameter int unsigned LO_W = 32,
   parameter int unsigned HI_W = 24,
   localparam int unsigned CW  = LO_W + HI_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_we,
   input  ctl_t            ctl_wd,
   input  logic            ivl_lo_we,
   input  logic            ivl_hi_we,
   input  logic [LO_W-1:0] wdata,
   output ctl_t            ctl,
   output logic [CW-1:0]   ivl,
   output logic [CW-1:0]   cnt,
   output logic            tick,
   output logic            expire
);
   ctl_t          ctl_q;
   logic [CW-1:0] ivl_q;
   logic [CW-1:0] cnt_q;

   dcount_prescale #(.SEL_W(PSEL_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctl_q.en),
      .sel   (ctl_q.psel),
      .tick  (tick)
   );

   assign expire = tick && !ctl_q.rld && (cnt_q <= CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ivl_q <= '0;
         cnt_q <= '0;
      end else begin
         if (ivl_lo_we) ivl_q[LO_W-1:0]  <= wdata;
         if (ivl_hi_we) ivl_q[CW-1:LO_W] <= wdata[HI_W-1:0];

         if (tick) begin
            if (ctl_q.rld)          cnt_q <= ivl_q;
            else if (expire)        cnt_q <= ctl_q.one_shot ? '0 : ivl_q;
            else                    cnt_q <= cnt_q - CW'(1);
         end

         if (ctl_we) begin
            ctl_q <= ctl_wd;
         end else begin
            if (tick)                      ctl_q.rld <= 1'b0;
            if (expire && ctl_q.one_shot)  ctl_q.en  <= 1'b0;
         end
      end
   end

   assign ctl = ctl_q;
   assign ivl = ivl_q;
   assign cnt = cnt_q;
endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
   import dcount_pkg::*;
#(
   parameter int unsigned NCH  = 4,
   parameter int unsigned DW   = 32,
   parameter int unsigned HI_W = 24,
   parameter int unsigned AW   = 8,
   localparam int unsigned CW  = DW + HI_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_sel,
   input  logic          acc_wr,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] acc_wdata,
   output logic [DW-1:0] acc_rdata,
   output logic          irq_o
);
   localparam int unsigned TOP_ADDR = CH_BASE + CH_STRIDE*(NCH-1) + CNT_HI_REL;

   if (NCH < 1 || NCH > DW) begin : g_bad_nch
      $error("dcount_timer: NCH must be 1..DW");
   end
   if (HI_W < 1 || HI_W > DW) begin : g_bad_hi
      $error("dcount_timer: HI_W must be 1..DW");
   end
   if (DW < 8) begin : g_bad_dw
      $error("dcount_timer: DW must hold the control word");
   end
   if (TOP_ADDR >= (1 << AW)) begin : g_bad_aw
      $error("dcount_timer: AW too narrow for NCH channels");
   end

   logic wr_hit, rd_hit;
   assign wr_hit = acc_sel && acc_wr;
   assign rd_hit = acc_sel && !acc_wr;

   logic [NCH-1:0]          ien_q, stat_q, st_clr;
   logic [NCH-1:0]          ch_en, ch_os, ch_rld, ch_tick, ch_expire, ch_ctl_we;
   logic [NCH-1:0][CW-1:0]  ch_cnt, ch_ivl;
   logic [DW-1:0]           ch_rd [NCH];

   ctl_t wr_ctl;
   assign wr_ctl = '{one_shot: acc_wdata[7], psel: acc_wdata[6:4],
                     rld: acc_wdata[1], en: acc_wdata[0]};

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam int unsigned BASE = CH_BASE + CH_STRIDE*n;
      localparam logic [AW-1:0] A_CTL = AW'(BASE + CTL_REL);
      localparam logic [AW-1:0] A_ILO = AW'(BASE + IVL_LO_REL);
      localparam logic [AW-1:0] A_IHI = AW'(BASE + IVL_HI_REL);
      localparam logic [AW-1:0] A_CLO = AW'(BASE + CNT_LO_REL);
      localparam logic [AW-1:0] A_CHI = AW'(BASE + CNT_HI_REL);

      ctl_t            ctl;
      logic [CW-1:0]   cnt, ivl;
      logic [HI_W-1:0] snap_q;

      assign ch_ctl_we[n] = wr_hit && (acc_addr == A_CTL);

      dcount_channel #(.LO_W(DW), .HI_W(HI_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_we    (ch_ctl_we[n]),
         .ctl_wd    (wr_ctl),
         .ivl_lo_we (wr_hit && (acc_addr == A_ILO)),
         .ivl_hi_we (wr_hit && (acc_addr == A_IHI)),
         .wdata     (acc_wdata),
         .ctl       (ctl),
         .ivl       (ivl),
         .cnt       (cnt),
         .tick      (ch_tick[n]),
         .expire    (ch_expire[n])
      );

      // upper count bits captured when the low word is read
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              snap_q <= '0;
         else if (rd_hit && (acc_addr == A_CLO))  snap_q <= cnt[CW-1:DW];
      end

      always_comb begin
         ch_rd[n] = '0;
         if (acc_addr == A_CTL)
            ch_rd[n] = DW'({ctl.one_shot, ctl.psel, 2'b00, ctl.rld, ctl.en});
         else if (acc_addr == A_ILO) ch_rd[n] = ivl[DW-1:0];
         else if (acc_addr == A_IHI) ch_rd[n] = DW'(ivl[CW-1:DW]);
         else if (acc_addr == A_CLO) ch_rd[n] = cnt[DW-1:0];
         else if (acc_addr == A_CHI) ch_rd[n] = DW'(snap_q);
      end

      assign ch_en[n]  = ctl.en;
      assign ch_os[n]  = ctl.one_shot;
      assign ch_rld[n] = ctl.rld;
      assign ch_cnt[n] = cnt;
      assign ch_ivl[n] = ivl;
   end

   assign st_clr = (wr_hit && (acc_addr == AW'(IST_OFS))) ? acc_wdata[NCH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= '0;
         stat_q <= '0;
      end else begin
         if (wr_hit && (acc_addr == AW'(IEN_OFS))) ien_q <= acc_wdata[NCH-1:0];
         stat_q <= (stat_q & ~st_clr) | ch_expire;
      end
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_addr == AW'(IEN_OFS)) acc_rdata = DW'(ien_q);
      if (acc_addr == AW'(IST_OFS)) acc_rdata = DW'(stat_q);
      for (int n = 0; n < NCH; n++) acc_rdata = acc_rdata | ch_rd[n];
   end

   assign irq_o = |(stat_q & ien_q);
endmodule

// File: rtl/dcount_timer_chk.sv
module dcount_timer_chk #(
   parameter int unsigned NCH = 4,
   parameter int unsigned CW  = 56
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   irq_o,
   input logic [NCH-1:0]         stat_q,
   input logic [NCH-1:0]         ch_en,
   input logic [NCH-1:0]         ch_os,
   input logic [NCH-1:0]         ch_rld,
   input logic [NCH-1:0]         ch_tick,
   input logic [NCH-1:0]         ch_expire,
   input logic [NCH-1:0]         ch_ctl_we,
   input logic [NCH-1:0][CW-1:0] ch_cnt,
   input logic [NCH-1:0][CW-1:0] ch_ivl
);
   // R9: the line is never raised without a pending status bit
   a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (stat_q != '0));

   for (genvar n = 0; n < NCH; n++) begin : g_a
      // R4
      a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
         ch_tick[n] && !ch_rld[n] && (ch_cnt[n] > CW'(1))
         |=> ch_cnt[n] == $past(ch_cnt[n]) - CW'(1));
      // R3
      a_r3_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
         ch_tick[n] && ch_rld[n] |=> ch_cnt[n] == $past(ch_ivl[n]));
      a_r3_reload_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
         ch_tick[n] && !ch_ctl_we[n] |=> !ch_rld[n]);
      // R5
      a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
         ch_expire[n] && !ch_os[n] |=> ch_cnt[n] == $past(ch_ivl[n]));
      // R6
      a_r6_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
         ch_expire[n] && ch_os[n] && !ch_ctl_we[n] |=> !ch_en[n] && (ch_cnt[n] == '0));
      // R8
      a_r8_expiry_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
         ch_expire[n] |=> stat_q[n]);
      // R10
      a_r10_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[n] |=> $stable(ch_cnt[n]));
      // R7
      a_r7_no_tick_when_off: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[n] |-> !ch_tick[n]);
   end
endmodule

bind dcount_timer dcount_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .stat_q    (stat_q),
   .ch_en     (ch_en),
   .ch_os     (ch_os),
   .ch_rld    (ch_rld),
   .ch_tick   (ch_tick),
   .ch_expire (ch_expire),
   .ch_ctl_we (ch_ctl_we),
   .ch_cnt    (ch_cnt),
   .ch_ivl    (ch_ivl)
);

// File: tb/sim_dcount_timer.sv
module sim_dcount_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0, probe = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   always #5 clk = ~clk;

   dcount_timer u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_sel   (sel),
      .acc_wr    (wr),
      .acc_addr  (addr),
      .acc_wdata (wdata),
      .acc_rdata (rdata),
      .irq_o     (irq)
   );

   typedef struct {
      logic        is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int total = 0;
   int bad   = 0;

   // each task occupies one access cycle, starting just after a rising edge
   task automatic slot();
      @(posedge clk); #1;
      sel = 1'b0; wr = 1'b0; probe = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      slot(); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
      slot(); sel = 1'b1; addr = a;
      sb.push_back('{1'b0, e, t});
   endtask

   task automatic irq_chk(input logic e, input string t);
      slot(); probe = 1'b1;
      sb.push_back('{1'b1, 32'(e), t});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot();
   endtask

   // monitor: mid-cycle comparison against the scoreboard
   always @(negedge clk) begin : mon
      item_t       it;
      logic [31:0] act;
      if (rst_n && (probe || (sel && !wr))) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R2 unexpected sample: got %h expected none", rdata);
         end else begin
            it  = sb.pop_front();
            act = it.is_irq ? 32'(irq) : rdata;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk(8'h00, 0, "R1 irq enable reset");
      rd_chk(8'h04, 0, "R1 status reset");
      rd_chk(8'h10, 0, "R1 control reset");
      rd_chk(8'h1C, 0, "R1 count reset");
      irq_chk(1'b0, "R1 irq low");

      // periodic, channel 0, interval 5, divide by 1
      wr_reg(8'h00, 32'h1);
      wr_reg(8'h14, 32'd5);
      wr_reg(8'h10, 32'h3);                                   // slot 0
      rd_chk(8'h10, 32'h3, "R3 reload bit held until tick");  // 1
      rd_chk(8'h10, 32'h1, "R3 reload bit self-cleared");     // 2
      rd_chk(8'h1C, 32'd4, "R4 count decrements");            // 3
      rd_chk(8'h04, 0, "R4 no early expiry");                 // 4
      idle(1);                                                // 5
      rd_chk(8'h04, 0, "R4 no expiry at count 1");            // 6
      rd_chk(8'h04, 32'h1, "R8 status set on expiry");        // 7
      rd_chk(8'h1C, 32'd4, "R5 interval reloaded");           // 8
      irq_chk(1'b1, "R9 irq with enable and status");         // 9
      wr_reg(8'h04, 32'h1);                                   // 10
      rd_chk(8'h04, 0, "R8 write one clears");                // 11
      rd_chk(8'h04, 32'h1, "R5 second expiry");               // 12
      wr_reg(8'h00, 0);                                       // 13
      irq_chk(1'b0, "R9 irq masked by enable");               // 14
      wr_reg(8'h04, 32'h1);                                   // 15
      idle(1);                                                // 16
      wr_reg(8'h10, 0);                                       // 17
      rd_chk(8'h1C, 32'd4, "R10 last tick at disabling edge");// 18
      idle(1);                                                // 19
      rd_chk(8'h1C, 32'd4, "R10 count frozen");               // 20
      rd_chk(8'h10, 0, "R10 control reads disabled");         // 21
      wr_reg(8'h04, 32'h1);

      // one-shot, channel 2, interval 3
      wr_reg(8'h00, 32'h4);
      wr_reg(8'h54, 32'd3);
      wr_reg(8'h50, 32'h83);                                  // 0
      rd_chk(8'h50, 32'h83, "R2 one-shot control readback");  // 1
      rd_chk(8'h5C, 32'd3, "R3 load in one-shot");            // 2
      rd_chk(8'h5C, 32'd2, "R4 one-shot decrement");          // 3
      rd_chk(8'h04, 0, "R6 not yet expired");                 // 4
      rd_chk(8'h04, 32'h4, "R6 status on channel 2 only");    // 5
      rd_chk(8'h50, 32'h80, "R6 enable cleared");             // 6
      rd_chk(8'h5C, 0, "R6 count at zero");                   // 7
      idle(1);                                                // 8
      rd_chk(8'h5C, 0, "R6 count stays zero");                // 9
      irq_chk(1'b1, "R9 irq from channel 2");                 // 10
      wr_reg(8'h04, 32'h4);                                   // 11
      idle(2);                                                // 12-13
      rd_chk(8'h04, 0, "R6 no second expiry");                // 14
      irq_chk(1'b0, "R9 irq drops after clear");              // 15

      // prescaler, channel 3, select 2 (divide by 4), interval 2
      wr_reg(8'h74, 32'd2);
      wr_reg(8'h70, 32'h23);                                  // 0
      idle(3);                                                // 1-3
      rd_chk(8'h7C, 0, "R7 no tick before 4 clocks");         // 4
      rd_chk(8'h7C, 32'd2, "R7 first tick after 4 clocks");   // 5
      idle(2);                                                // 6-7
      rd_chk(8'h7C, 32'd2, "R7 held between ticks");          // 8
      rd_chk(8'h7C, 32'd1, "R7 second tick");                 // 9
      idle(2);                                                // 10-11
      rd_chk(8'h04, 0, "R7 no early expiry");                 // 12
      rd_chk(8'h04, 32'h8, "R7 expiry after 8 clocks");       // 13
      wr_reg(8'h70, 32'h20);                                  // 14
      wr_reg(8'h74, 32'd7);                                   // 15
      wr_reg(8'h70, 32'h23);                                  // 16
      idle(3);                                                // 17-19
      rd_chk(8'h7C, 32'd2, "R7 prescaler restarted at zero"); // 20
      rd_chk(8'h7C, 32'd7, "R7 reload after full division");  // 21
      wr_reg(8'h70, 0);
      wr_reg(8'h04, 32'h8);

      // 56-bit snapshot, channel 1, interval 0x1_00000001
      wr_reg(8'h34, 32'h1);
      wr_reg(8'h38, 32'h1);
      wr_reg(8'h30, 32'h3);                                   // c
      idle(2);                                                // c+1, c+2
      rd_chk(8'h3C, 32'h0, "R11 low word");                   // c+3
      rd_chk(8'h40, 32'h1, "R11 high word from snapshot");    // c+4
      rd_chk(8'h3C, 32'hFFFF_FFFE, "R11 low word borrow");    // c+5
      rd_chk(8'h40, 32'h0, "R11 snapshot refreshed");         // c+6
      wr_reg(8'h30, 0);
      wr_reg(8'h38, 32'hFFFF_FFFF);
      rd_chk(8'h38, 32'h00FF_FFFF, "R2 interval high is 24 bits");
      rd_chk(8'h34, 32'h1, "R2 interval low readback");

      slot();
      @(negedge clk); #1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule